// File: doc/BRIEF.md
# Hierarchical Delay-Line Setting Stepper

This block keeps the delay setting of one data lane as four nested fields: a coarse bit (0..1), a clock-delay field (0..2), a tap field (0..tap ceiling) and a phase-interpolator field (0..6). A training engine asks it to move the setting one unit later or one unit earlier, or loads a starting setting directly. After every accepted change the block derives two delay-bypass control bits, an enable and a select, from the new tap and phase values against thresholds chosen by a 2-bit speed code.

The carry chain is not a plain mixed-radix counter. When a step carries into the coarse bit, the clock-delay field moves in the opposite direction. The tap ceiling and the bypass thresholds both depend on the speed code. Each request is answered one clock later with a one-cycle `done_o` pulse, or with an `err_o` pulse that leaves every output unchanged.

Top module: `dly_setting_stepper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all four fields, both bypass bits, `done_o` and `err_o` read 0.
- R2: An increment adds one to phase if phase < 6. Otherwise, if tap < ceiling, it clears phase and adds one to tap. Otherwise, if clock delay < 2, it clears phase and tap and adds one to clock delay.
- R3: An increment with phase 6, tap at the ceiling and clock delay 2 sets coarse to 1, clears phase and tap, and lowers clock delay by one if coarse was 0. If coarse was already 1, the increment fails.
- R4: A decrement subtracts one from phase if phase > 0. Otherwise, if tap > 0, it lowers tap by one and sets phase to 6. Otherwise, if clock delay > 0, it lowers clock delay by one and sets tap to the ceiling and phase to 6.
- R5: A decrement from phase 0, tap 0, clock delay 0 with coarse 1 clears coarse, raises clock delay by one, and sets tap to the ceiling and phase to 6. With all four fields at zero the decrement fails.
- R6: The tap ceiling is 12 for speed code 0, 10 for code 1 and 13 for code 2. Code 3 behaves exactly like code 0.
- R7: Take the thresholds (tap low, tap high, phase low, phase high) as (3,10,2,3) for code 0, (2,8,6,7) for code 1 and (3,11,6,4) for code 2. Enable=1 and select=1 when tap < tap low, or when tap = tap low and phase < phase low. Otherwise enable=0 and select=0 when tap < tap high, or when tap = tap high and phase < phase high. Otherwise enable=1 and select=0.
- R8: The bypass bits change only on a load or a successful step. A failed step, or a change of speed code with no strobe, leaves them unchanged.
- R9: `load_i` writes all four fields from the load inputs and recomputes the bypass bits. A load takes priority over any increment or decrement in the same cycle, and it answers with `done_o`, never with `err_o`.
- R10: An increment and a decrement in the same cycle, without a load, raise `err_o` and leave all outputs unchanged.
- R11: The result of a strobe appears in the cycle after it is sampled, together with exactly one of `done_o` or `err_o` for one cycle. A cycle with no strobe produces no pulse and no change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_i | input | 2 | Memory clock speed code |
| inc_i | input | 1 | Step one unit later |
| dec_i | input | 1 | Step one unit earlier |
| load_i | input | 1 | Write the load fields |
| ld_coarse_i | input | 1 | Load value for coarse |
| ld_clkdly_i | input | 2 | Load value for clock delay |
| ld_tap_i | input | 4 | Load value for tap |
| ld_phase_i | input | 3 | Load value for phase |
| coarse_o | output | 1 | Current coarse field |
| clkdly_o | output | 2 | Current clock-delay field |
| tap_o | output | 4 | Current tap field |
| phase_o | output | 3 | Current phase field |
| byp_en_o | output | 1 | Bypass enable bit |
| byp_sel_o | output | 1 | Bypass select bit |
| done_o | output | 1 | One-cycle pulse: request accepted |
| err_o | output | 1 | One-cycle pulse: request refused |

## Verification
A load and a step can arrive in the same cycle, and so can an increment and a decrement. The bench provokes both collisions by raising the strobes together on one falling edge. A load that meets an increment is judged correct if the loaded fields appear, with `done_o` high and `err_o` low. A clashing increment and decrement is judged correct if `err_o` pulses and every field and bypass bit is unchanged.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;

    parameter int TAP_W = 4;
    parameter int PH_W  = 3;
    parameter int CLK_W = 2;
    parameter int SPD_W = 2;

    localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(6);
    localparam logic [CLK_W-1:0] CLK_TOP = CLK_W'(2);

    typedef logic [SPD_W-1:0] speed_t;

    typedef struct packed {
        logic             coarse;
        logic [CLK_W-1:0] clk;
        logic [TAP_W-1:0] tap;
        logic [PH_W-1:0]  ph;
    } dly_set_t;

    typedef struct packed {
        logic [TAP_W-1:0] t_lo;
        logic [TAP_W-1:0] t_hi;
        logic [PH_W-1:0]  p_lo;
        logic [PH_W-1:0]  p_hi;
    } byp_lim_t;

    typedef struct packed {
        logic en;
        logic sel;
    } byp_t;

    function automatic logic [TAP_W-1:0] tap_ceiling(speed_t s);
        case (s)
            SPD_W'(1): return TAP_W'(10);
            SPD_W'(2): return TAP_W'(13);
            default:   return TAP_W'(12);
        endcase
    endfunction

    function automatic byp_lim_t byp_limits(speed_t s);
        byp_lim_t l;
        case (s)
            SPD_W'(1): l = '{t_lo: TAP_W'(2), t_hi: TAP_W'(8),  p_lo: PH_W'(6), p_hi: PH_W'(7)};
            SPD_W'(2): l = '{t_lo: TAP_W'(3), t_hi: TAP_W'(11), p_lo: PH_W'(6), p_hi: PH_W'(4)};
            default:   l = '{t_lo: TAP_W'(3), t_hi: TAP_W'(10), p_lo: PH_W'(2), p_hi: PH_W'(3)};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/dly_step_next.sv
module dly_step_next
    import dly_step_pkg::*;
(
    input  dly_set_t cur_i,
    input  speed_t   speed_i,
    input  logic     up_i,
    output dly_set_t nxt_o,
    output logic     ok_o
);
    logic [TAP_W-1:0] ceil_w;

    always_comb begin
        ceil_w = tap_ceiling(speed_i);
        nxt_o  = cur_i;
        ok_o   = 1'b1;
        if (up_i) begin
            if (cur_i.ph < PH_TOP) begin
                nxt_o.ph = cur_i.ph + 1'b1;
            end else if (cur_i.tap < ceil_w) begin
                nxt_o.ph  = '0;
                nxt_o.tap = cur_i.tap + 1'b1;
            end else if (cur_i.clk < CLK_TOP) begin
                nxt_o.ph  = '0;
                nxt_o.tap = '0;
                nxt_o.clk = cur_i.clk + 1'b1;
            end else if (!cur_i.coarse) begin
                nxt_o.ph     = '0;
                nxt_o.tap    = '0;
                nxt_o.clk    = cur_i.clk - 1'b1;
                nxt_o.coarse = 1'b1;
            end else begin
                ok_o = 1'b0;
            end
        end else begin
            if (cur_i.ph != '0) begin
                nxt_o.ph = cur_i.ph - 1'b1;
            end else if (cur_i.tap != '0) begin
                nxt_o.ph  = PH_TOP;
                nxt_o.tap = cur_i.tap - 1'b1;
            end else if (cur_i.clk != '0) begin
                nxt_o.ph  = PH_TOP;
                nxt_o.tap = ceil_w;
                nxt_o.clk = cur_i.clk - 1'b1;
            end else if (cur_i.coarse) begin
                nxt_o.ph     = PH_TOP;
                nxt_o.tap    = ceil_w;
                nxt_o.clk    = cur_i.clk + 1'b1;
                nxt_o.coarse = 1'b0;
            end else begin
                ok_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dly_bypass_calc.sv
module dly_bypass_calc
    import dly_step_pkg::*;
(
    input  dly_set_t set_i,
    input  speed_t   speed_i,
    output byp_t     byp_o
);
    byp_lim_t lim;
    logic     below_lo;
    logic     below_hi;

    always_comb begin
        lim      = byp_limits(speed_i);
        below_lo = (set_i.tap < lim.t_lo) ||
                   ((set_i.tap == lim.t_lo) && (set_i.ph < lim.p_lo));
        below_hi = (set_i.tap < lim.t_hi) ||
                   ((set_i.tap == lim.t_hi) && (set_i.ph < lim.p_hi));
        if (below_lo)      byp_o = '{en: 1'b1, sel: 1'b1};
        else if (below_hi) byp_o = '{en: 1'b0, sel: 1'b0};
        else               byp_o = '{en: 1'b1, sel: 1'b0};
    end
endmodule

// File: rtl/dly_setting_stepper.sv
module dly_setting_stepper
    import dly_step_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SPD_W-1:0] speed_i,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             load_i,
    input  logic             ld_coarse_i,
    input  logic [CLK_W-1:0] ld_clkdly_i,
    input  logic [TAP_W-1:0] ld_tap_i,
    input  logic [PH_W-1:0]  ld_phase_i,
    output logic             coarse_o,
    output logic [CLK_W-1:0] clkdly_o,
    output logic [TAP_W-1:0] tap_o,
    output logic [PH_W-1:0]  phase_o,
    output logic             byp_en_o,
    output logic             byp_sel_o,
    output logic             done_o,
    output logic             err_o
);
    dly_set_t cur_q;
    byp_t     byp_q;
    dly_set_t step_w;
    dly_set_t cand_w;
    byp_t     byp_w;
    logic     step_ok_w;
    logic     clash_w;
    logic     accept_w;

    dly_step_next u_next (
        .cur_i   (cur_q),
        .speed_i (speed_i),
        .up_i    (inc_i),
        .nxt_o   (step_w),
        .ok_o    (step_ok_w)
    );

    always_comb begin
        clash_w = inc_i && dec_i;
        if (load_i) begin
            cand_w   = '{coarse: ld_coarse_i, clk: ld_clkdly_i,
                         tap: ld_tap_i, ph: ld_phase_i};
            accept_w = 1'b1;
        end else begin
            cand_w   = step_w;
            accept_w = (inc_i ^ dec_i) && step_ok_w;
        end
    end

    dly_bypass_calc u_byp (
        .set_i   (cand_w),
        .speed_i (speed_i),
        .byp_o   (byp_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            byp_q  <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= accept_w;
            err_o  <= !load_i && (clash_w || ((inc_i || dec_i) && !step_ok_w));
            if (accept_w) begin
                cur_q <= cand_w;
                byp_q <= byp_w;
            end
        end
    end

    assign coarse_o  = cur_q.coarse;
    assign clkdly_o  = cur_q.clk;
    assign tap_o     = cur_q.tap;
    assign phase_o   = cur_q.ph;
    assign byp_en_o  = byp_q.en;
    assign byp_sel_o = byp_q.sel;
endmodule

// File: rtl/dly_stepper_chk.sv
module dly_stepper_chk
    import dly_step_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             inc_i,
    input logic             dec_i,
    input logic             load_i,
    input logic             coarse_o,
    input logic [CLK_W-1:0] clkdly_o,
    input logic [TAP_W-1:0] tap_o,
    input logic [PH_W-1:0]  phase_o,
    input logic             byp_en_o,
    input logic             byp_sel_o,
    input logic             done_o,
    input logic             err_o
);
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o)); // R11

    AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable({coarse_o, clkdly_o, tap_o, phase_o}) &&
                   $stable({byp_en_o, byp_sel_o}))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(inc_i || dec_i || load_i) |=> (!done_o && !err_o &&
            $stable({coarse_o, clkdly_o, tap_o, phase_o, byp_en_o, byp_sel_o}))); // R11

    AST_LOAD_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (done_o && !err_o)); // R9

    AST_CLASH_ERR: assert property (@(posedge clk) disable iff (rst)
        (inc_i && dec_i && !load_i) |=> (err_o && !done_o)); // R10

    AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        byp_sel_o |-> byp_en_o); // R7
endmodule

bind dly_setting_stepper dly_stepper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .inc_i     (inc_i),
    .dec_i     (dec_i),
    .load_i    (load_i),
    .coarse_o  (coarse_o),
    .clkdly_o  (clkdly_o),
    .tap_o     (tap_o),
    .phase_o   (phase_o),
    .byp_en_o  (byp_en_o),
    .byp_sel_o (byp_sel_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/dly_setting_stepper_tb.sv
module dly_setting_stepper_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed = 2'd0;
    logic       inc = 1'b0, dec = 1'b0, load = 1'b0;
    logic       l_c = 1'b0;
    logic [1:0] l_k = '0;
    logic [3:0] l_t = '0;
    logic [2:0] l_p = '0;
    logic       coarse;
    logic [1:0] clkdly;
    logic [3:0] tap;
    logic [2:0] phase;
    logic       en, sel, done, err;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dly_setting_stepper u_dut (
        .clk(clk), .rst(rst), .speed_i(speed), .inc_i(inc), .dec_i(dec),
        .load_i(load), .ld_coarse_i(l_c), .ld_clkdly_i(l_k), .ld_tap_i(l_t),
        .ld_phase_i(l_p), .coarse_o(coarse), .clkdly_o(clkdly), .tap_o(tap),
        .phase_o(phase), .byp_en_o(en), .byp_sel_o(sel), .done_o(done), .err_o(err)
    );

    task automatic check(string req, logic c, logic [1:0] k, logic [3:0] t,
                         logic [2:0] p, logic e, logic s, logic d, logic x);
        logic [13:0] act, exp;
        act = {coarse, clkdly, tap, phase, en, sel, done, err};
        exp = {c, k, t, p, e, s, d, x};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual c%0d k%0d t%0d p%0d en%0d sel%0d done%0d err%0d expected c%0d k%0d t%0d p%0d en%0d sel%0d done%0d err%0d",
                     req, coarse, clkdly, tap, phase, en, sel, done, err, c, k, t, p, e, s, d, x);
        end
    endtask

    // Strobes are raised on a falling edge and results read on the next one.
    task automatic strobe(logic i, logic d, logic l, logic c, logic [1:0] k,
                          logic [3:0] t, logic [2:0] p);
        @(negedge clk);
        inc = i; dec = d; load = l; l_c = c; l_k = k; l_t = t; l_p = p;
        @(negedge clk);
        inc = 1'b0; dec = 1'b0; load = 1'b0;
    endtask

    task automatic do_load(logic c, logic [1:0] k, logic [3:0] t, logic [2:0] p);
        strobe(1'b0, 1'b0, 1'b1, c, k, t, p);
    endtask

    task automatic do_inc();
        strobe(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 3'd0);
    endtask

    task automatic do_dec();
        strobe(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 3'd0);
    endtask

    task automatic t_reset();
        check("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_inc_chain();
        speed = 2'd0;
        do_load(0, 0, 0, 5); check("R9 load", 0, 0, 0, 5, 1, 1, 1, 0);
        do_inc();            check("R2 phase up", 0, 0, 0, 6, 1, 1, 1, 0);
        do_inc();            check("R2 tap up", 0, 0, 1, 0, 1, 1, 1, 0);
        do_load(0, 0, 12, 6); check("R7 above high", 0, 0, 12, 6, 1, 0, 1, 0);
        do_inc();            check("R2 clkdly up", 0, 1, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_thresholds();
        speed = 2'd0;
        do_load(0, 0, 3, 1); check("R7 at tap low", 0, 0, 3, 1, 1, 1, 1, 0);
        do_inc();            check("R7 middle band", 0, 0, 3, 2, 0, 0, 1, 0);
        do_load(0, 0, 10, 2); check("R7 at tap high", 0, 0, 10, 2, 0, 0, 1, 0);
        do_inc();            check("R7 past high", 0, 0, 10, 3, 1, 0, 1, 0);
        speed = 2'd2;
        do_load(0, 0, 11, 3); check("R7 speed2 at high", 0, 0, 11, 3, 0, 0, 1, 0);
        do_inc();            check("R7 speed2 past high", 0, 0, 11, 4, 1, 0, 1, 0);
    endtask

    task automatic t_speeds();
        speed = 2'd1;
        do_load(0, 0, 10, 6); check("R6 speed1 load", 0, 0, 10, 6, 1, 0, 1, 0);
        do_inc();            check("R6 speed1 ceiling 10", 0, 1, 0, 0, 1, 1, 1, 0);
        speed = 2'd2;
        do_load(0, 0, 12, 6); do_inc();
        check("R6 speed2 ceiling 13", 0, 0, 13, 0, 1, 0, 1, 0);
        speed = 2'd3;
        do_load(0, 0, 12, 6); do_inc();
        check("R6 code3 as code0", 0, 1, 0, 0, 1, 1, 1, 0);
        speed = 2'd0;
    endtask

    task automatic t_coarse_up();
        speed = 2'd0;
        do_load(0, 2, 12, 6); do_inc();
        check("R3 carry into coarse", 1, 1, 0, 0, 1, 1, 1, 0);
        do_load(1, 2, 12, 6); check("R3 top load", 1, 2, 12, 6, 1, 0, 1, 0);
        do_inc();            check("R3 increment fails", 1, 2, 12, 6, 1, 0, 0, 1);
    endtask

    task automatic t_dec_chain();
        speed = 2'd0;
        do_load(0, 1, 0, 0); do_dec();
        check("R4 clkdly down", 0, 0, 12, 6, 1, 0, 1, 0);
        do_dec();            check("R4 phase down", 0, 0, 12, 5, 1, 0, 1, 0);
        do_load(0, 0, 4, 0); do_dec();
        check("R4 tap down", 0, 0, 3, 6, 0, 0, 1, 0);
        do_load(1, 0, 0, 0); do_dec();
        check("R5 coarse borrow", 0, 1, 12, 6, 1, 0, 1, 0);
        speed = 2'd1;
        do_load(1, 0, 0, 0); do_dec();
        check("R5 borrow speed1", 0, 1, 10, 6, 1, 0, 1, 0);
        speed = 2'd0;
        do_load(0, 0, 0, 0); do_dec();
        check("R5 decrement at zero fails", 0, 0, 0, 0, 1, 1, 0, 1);
    endtask

    task automatic t_collisions();
        speed = 2'd0;
        do_load(0, 0, 5, 3);
        strobe(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 3'd0);
        check("R10 inc and dec clash", 0, 0, 5, 3, 0, 0, 0, 1);
        strobe(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd7, 3'd1);
        check("R9 load beats inc", 0, 0, 7, 1, 0, 0, 1, 0);
        strobe(1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 4'd0, 3'd0);
        check("R9 load beats clash", 1, 1, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_idle();
        speed = 2'd0;
        do_load(0, 0, 3, 1); check("R9 load", 0, 0, 3, 1, 1, 1, 1, 0);
        speed = 2'd1;
        @(negedge clk);
        check("R11 pulse ends", 0, 0, 3, 1, 1, 1, 0, 0);
        @(negedge clk);
        check("R8 speed change alone", 0, 0, 3, 1, 1, 1, 0, 0);
        do_inc();
        check("R8 recompute on step", 0, 0, 3, 2, 0, 0, 1, 0);
        speed = 2'd0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_inc_chain();
        t_thresholds();
        t_speeds();
        t_coarse_up();
        t_dec_chain();
        t_collisions();
        t_idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule